// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache Controller

This block is the control side of a small two-way set-associative instruction cache. It holds the tags, valid bits, lock bits, replacement state and one 32-bit word per line in register arrays. Each fetch is answered from the cache on a hit. On a miss the block waits one penalty cycle, requests the word from memory, returns it, and decides whether and where to keep it. One 8-bit control register governs both ways. It carries an enable, a flush pulse, an unlock pulse, an auto-lock mode, a sticky lock-failure flag and a global lock.

Three interfaces carry data, and each uses valid/ready. A fetch is accepted when `fetch_valid` and `fetch_ready` are both high, and `fetch_ready` is high only while no fetch is in flight. The answer is held on `rsp_valid`, `rsp_data` and `rsp_hit`, unchanged, until `rsp_ready` is high at a clock edge. The memory request is held until `mem_req_ready` is seen. The refill word is taken when `mem_rsp_valid` and `mem_rsp_ready` are both high. The register port is plain: a write strobe, write data and a read-back value that always shows the current register contents.

Control writes reach the cache through a fixed pipeline. A fetch accepted shortly after a write is therefore still cached under the old settings. Address bits [1:0] select a byte within the word, bits [2+:log2(SETS)] select the set, and the bits above those form the tag.

Top module: `icache_lock_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `fetch_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. All lines are invalid and unlocked.
- R2: The register fields are: bit0 enable, bit1 flush, bit2 unlock, bit3 auto-lock, bit4 lock-fail flag, bit5 global lock. Bits 7:6 always read 0. A written 1 in flush or in unlock reads back as 1 for exactly one cycle and then reads 0.
- R3: A fetch accepted at the same edge as a register write, or at any of the next three edges, is cached under the previous settings. A fetch accepted at the fourth edge or later uses the new settings.
- R4: While enable is 0, every fetch is reported as a miss, its word comes from memory, and nothing is written into the cache.
- R5: A hit returns the stored word with `rsp_hit`=1. A miss requests the word from memory at the fetch address and returns it with `rsp_hit`=0.
- R6: After a missing fetch is accepted there is exactly one idle cycle before `mem_req_valid` rises. This holds even while the global lock is set.
- R7: A fill goes to the lowest-numbered invalid way of the set. If both ways are valid and unlocked, it goes to the least recently used way (hits and fills both count as use). If both are valid and exactly one is unlocked, it goes to the unlocked way.
- R8: While the global lock is 1, a miss never replaces a valid line, but an invalid way is still filled.
- R9: A valid locked line is never replaced. A locked line that is invalid may still be filled.
- R10: With auto-lock on, the line written by a fill gets its lock bit set.
- R11: The lock-fail flag is set when an auto-lock miss finds every way of its set locked. It stays 1 until a write with bit4=0 clears it. If a hardware set and a clearing write fall in the same cycle, the set wins.
- R12: An effective unlock pulse clears every lock bit, and an effective flush pulse clears every valid bit while leaving the lock bits unchanged.
- R13: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its data and hit flag are stable, and `fetch_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Control register write data (bits 5:0) |
| reg_rdata | output | 8 | Control register read-back |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Block can accept a fetch |
| fetch_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Fetched instruction word |
| rsp_hit | output | 1 | 1 when the fetch hit the cache |
| mem_req_valid | output | 1 | Refill request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Refill address |
| mem_rsp_valid | input | 1 | Refill word valid |
| mem_rsp_ready | output | 1 | Block can take the refill word |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
Two events can land on the same edge: hardware setting the lock-fail flag when an auto-lock refill completes, and a software write that clears that flag. The bench provokes this by holding an auto-locked set full and issuing a conflicting miss. It drives the refill word and a clearing register write in the same cycle. Reading the register afterwards must show the flag still set. Separate checks show that a clearing write on its own does clear the flag.

// File: rtl/icl_pkg.sv
package icl_pkg;
  localparam int unsigned NWAYS = 2;
  localparam int unsigned WAY_W = 1;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_FL   = 1;
  localparam int unsigned B_UL   = 2;
  localparam int unsigned B_AL   = 3;
  localparam int unsigned B_FAIL = 4;
  localparam int unsigned B_GL   = 5;

  typedef struct packed {
    logic glock;
    logic alock;
    logic unlock;
    logic flush;
    logic en;
  } ctl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_PEN, ST_REQ, ST_WAIT, ST_RSP} st_t;
endpackage

// File: rtl/icl_ctrl_reg.sv
module icl_ctrl_reg
  import icl_pkg::*;
#(
  parameter int unsigned LAG = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  input  logic       fail_set,
  output logic [7:0] rd_data,
  output ctl_t       eff
);
  logic en_q, fl_q, ul_q, al_q, fail_q, gl_q;
  ctl_t sw;
  ctl_t stg [LAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fl_q   <= 1'b0;
      ul_q   <= 1'b0;
      al_q   <= 1'b0;
      fail_q <= 1'b0;
      gl_q   <= 1'b0;
    end else begin
      fl_q   <= wr_en & wr_data[B_FL];
      ul_q   <= wr_en & wr_data[B_UL];
      fail_q <= fail_set | (fail_q & ~(wr_en & ~wr_data[B_FAIL]));
      if (wr_en) begin
        en_q <= wr_data[B_EN];
        al_q <= wr_data[B_AL];
        gl_q <= wr_data[B_GL];
      end
    end
  end

  assign rd_data = {2'b00, gl_q, fail_q, al_q, ul_q, fl_q, en_q};
  assign sw = '{glock: gl_q, alock: al_q, unlock: ul_q, flush: fl_q, en: en_q};

  // Settings reach the cache only after LAG register stages.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG; i++) stg[i] <= '0;
    end else begin
      stg[0] <= sw;
      for (int i = 1; i < LAG; i++) stg[i] <= stg[i-1];
    end
  end

  assign eff = stg[LAG-1];

  // R11: the fail flag only drops through a clearing write
  p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !(wr_en && !wr_data[B_FAIL]) |=> fail_q);

  // R2: pulse bits read high one cycle only
  p_unlock_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ul_q && !(wr_en && wr_data[B_UL]) |=> !ul_q);
endmodule

// File: rtl/icl_victim_sel.sv
module icl_victim_sel
  import icl_pkg::*;
(
  input  logic [NWAYS-1:0] vld_i,
  input  logic [NWAYS-1:0] lck_i,
  input  logic [WAY_W-1:0] lru_i,
  input  logic             glock_i,
  output logic             ok_o,
  output logic [WAY_W-1:0] way_o,
  output logic             all_lck_o
);
  logic [NWAYS-1:0] unl;

  assign unl       = ~lck_i;
  assign all_lck_o = &lck_i;

  always_comb begin
    ok_o  = 1'b0;
    way_o = '0;
    // Invalid ways are always fillable, lowest index first.
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        ok_o  = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    if (!ok_o && !glock_i) begin
      if (&unl) begin
        ok_o  = 1'b1;
        way_o = lru_i;
      end else begin
        for (int w = NWAYS - 1; w >= 0; w--) begin
          if (unl[w]) begin
            ok_o  = 1'b1;
            way_o = WAY_W'(w);
          end
        end
      end
    end
  end
endmodule

// File: rtl/icl_tag_store.sv
module icl_tag_store
  import icl_pkg::*;
#(
  parameter int unsigned SETS   = 4,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [NWAYS-1:0]  hit_vec,
  output logic [DATA_W-1:0] hit_data,
  input  logic [IDX_W-1:0]  vs_idx,
  output logic [NWAYS-1:0]  set_vld,
  output logic [NWAYS-1:0]  set_lck,
  output logic [WAY_W-1:0]  set_lru,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_lock,
  input  logic              use_en,
  input  logic [IDX_W-1:0]  use_idx,
  input  logic [WAY_W-1:0]  use_way,
  input  logic              flush,
  input  logic              unlock
);
  logic [NWAYS-1:0][SETS-1:0] vld_q, lck_q;
  logic [TAG_W-1:0]  tag_q [NWAYS][SETS];
  logic [DATA_W-1:0] dat_q [NWAYS][SETS];
  logic [SETS-1:0]   lru_q;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign hit_vec[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    assign set_vld[w] = vld_q[w][vs_idx];
    assign set_lck[w] = lck_q[w][vs_idx];
  end

  assign hit_data = hit_vec[1] ? dat_q[1][lk_idx] : dat_q[0][lk_idx];
  assign set_lru  = lru_q[vs_idx];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_way][fill_idx] <= fill_tag;
      dat_q[fill_way][fill_idx] <= fill_data;
    end
  end

  // Flush and unlock override a fill in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lck_q <= '0;
      lru_q <= '0;
    end else begin
      if (fill_en) begin
        vld_q[fill_way][fill_idx] <= 1'b1;
        if (fill_lock) lck_q[fill_way][fill_idx] <= 1'b1;
      end
      if (use_en) lru_q[use_idx] <= ~use_way;
      if (flush)  vld_q <= '0;
      if (unlock) lck_q <= '0;
    end
  end

  // R12: effective flush empties the cache
  p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R12: effective unlock clears all locks
  p_unlock_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (lck_q == '0));
endmodule

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl
  import icl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 4,
  parameter int unsigned LAG    = 3,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - 2 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  st_t               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              hit_q;
  logic              c_en, c_al, c_gl;
  ctl_t              eff;

  logic [IDX_W-1:0]  lk_idx, q_idx;
  logic [TAG_W-1:0]  lk_tag, q_tag;
  logic [NWAYS-1:0]  hit_vec, set_vld, set_lck;
  logic [DATA_W-1:0] hit_data;
  logic [WAY_W-1:0]  set_lru, vic_way, use_way;
  logic              vic_ok, vic_all_lck;
  logic              accept, hit_any, fill_evt, fill_en, fill_lock, fail_set, use_en;
  logic [IDX_W-1:0]  use_idx;

  assign lk_idx = fetch_addr[2 +: IDX_W];
  assign lk_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  assign q_idx  = addr_q[2 +: IDX_W];
  assign q_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign accept    = fetch_valid && (st_q == ST_IDLE);
  assign hit_any   = eff.en && (|hit_vec);
  assign fill_evt  = (st_q == ST_WAIT) && mem_rsp_valid;
  assign fill_en   = fill_evt && c_en && vic_ok;
  assign fill_lock = c_al && !set_lck[vic_way];
  assign fail_set  = fill_evt && c_en && c_al && vic_all_lck;
  assign use_en    = (accept && hit_any) || fill_en;
  assign use_idx   = accept ? lk_idx : q_idx;
  assign use_way   = accept ? WAY_W'(hit_vec[1]) : vic_way;

  icl_ctrl_reg #(.LAG(LAG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_data  (reg_wdata),
    .fail_set (fail_set),
    .rd_data  (reg_rdata),
    .eff      (eff)
  );

  icl_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .hit_vec   (hit_vec),
    .hit_data  (hit_data),
    .vs_idx    (q_idx),
    .set_vld   (set_vld),
    .set_lck   (set_lck),
    .set_lru   (set_lru),
    .fill_en   (fill_en),
    .fill_way  (vic_way),
    .fill_idx  (q_idx),
    .fill_tag  (q_tag),
    .fill_data (mem_rsp_data),
    .fill_lock (fill_lock),
    .use_en    (use_en),
    .use_idx   (use_idx),
    .use_way   (use_way),
    .flush     (eff.flush),
    .unlock    (eff.unlock)
  );

  icl_victim_sel u_vic (
    .vld_i     (set_vld),
    .lck_i     (set_lck),
    .lru_i     (set_lru),
    .glock_i   (c_gl),
    .ok_o      (vic_ok),
    .way_o     (vic_way),
    .all_lck_o (vic_all_lck)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      hit_q  <= 1'b0;
      c_en   <= 1'b0;
      c_al   <= 1'b0;
      c_gl   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q <= fetch_addr;
          c_en   <= eff.en;
          c_al   <= eff.alock;
          c_gl   <= eff.glock;
          if (hit_any) begin
            data_q <= hit_data;
            hit_q  <= 1'b1;
            st_q   <= ST_RSP;
          end else begin
            st_q   <= ST_PEN;
          end
        end
        ST_PEN:  st_q <= ST_REQ;
        ST_REQ:  if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          hit_q  <= 1'b0;
          st_q   <= ST_RSP;
        end
        ST_RSP:  if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready   = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st_q == ST_WAIT);
  assign rsp_valid     = (st_q == ST_RSP);
  assign rsp_data      = data_q;
  assign rsp_hit       = hit_q;

  // R6: one idle cycle between a missing accept and the request
  p_one_penalty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit_any |=> !mem_req_valid ##1 mem_req_valid);

  // R13: response held under back-pressure
  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit) && !fetch_ready);

  // R8: under global lock no valid way is chosen
  p_glock_no_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && c_gl |-> !set_vld[vic_way]);

  // R9: a valid locked line is never the victim
  p_locked_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !(set_vld[vic_way] && set_lck[vic_way]));
endmodule

// File: tb/icache_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module icache_lock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int last_req_n;

  localparam logic [31:0] A0 = 32'h0000_0100;
  localparam logic [31:0] A1 = 32'h0000_0200;
  localparam logic [31:0] A2 = 32'h0000_0300;

  always #2.5 clk = ~clk;

  icache_lock_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .reg_we (reg_we), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .fetch_valid (fetch_valid), .fetch_ready (fetch_ready), .fetch_addr (fetch_addr),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data), .rsp_hit (rsp_hit),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready), .mem_req_addr (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_ready (mem_rsp_ready), .mem_rsp_data (mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic reg_write(input logic [5:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_fetch(input logic [31:0] a, input int hold, input logic wr_at_fill,
                          input logic [5:0] wv, output logic hit, output logic [31:0] d);
    int n;
    fetch_valid = 1'b1; fetch_addr = a;
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    n = 0; last_req_n = -1;
    while (!rsp_valid && n < 50) begin
      if (mem_req_valid && last_req_n < 0) last_req_n = n;
      if (mem_rsp_ready) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(mem_req_addr);
        if (wr_at_fill) begin reg_we = 1'b1; reg_wdata = wv; end
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0; reg_we = 1'b0;
      n++;
    end
    hit = rsp_hit; d = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R13 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
      chk("R13 data stable", rsp_data, d);
      chk("R13 fetch_ready low", {31'd0, fetch_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_fetch(input logic [31:0] a, input logic exp_hit, input string rq);
    logic h; logic [31:0] d;
    do_fetch(a, 0, 1'b0, 6'd0, h, d);
    chk({rq, " hit flag"}, {31'd0, h}, {31'd0, exp_hit});
    chk({rq, " data"}, d, mem_word(a));
  endtask

  task automatic t_reset();
    chk("R1 reg reset", {24'd0, reg_rdata}, 32'h00);
    chk("R1 fetch_ready", {31'd0, fetch_ready}, 32'd1);
    chk("R1 idle outputs", {30'd0, rsp_valid, mem_req_valid}, 32'd0);
  endtask

  task automatic t_disabled();
    expect_fetch(A0, 1'b0, "R4 disabled first");
    expect_fetch(A0, 1'b0, "R4 disabled no fill");
    reg_write(6'h01);
    chk("R2 upper bits zero", {24'd0, reg_rdata}, 32'h01);
    settle();
  endtask

  task automatic t_fill_lru();
    expect_fetch(A0, 1'b0, "R5 miss A0");
    chk("R6 penalty cycle", last_req_n, 1);
    expect_fetch(A0, 1'b1, "R5 hit A0");
    expect_fetch(A1, 1'b0, "R7 fill invalid way");
    expect_fetch(A0, 1'b1, "R7 A0 kept");
    expect_fetch(A2, 1'b0, "R7 miss A2 evicts lru");
    expect_fetch(A0, 1'b1, "R7 mru A0 kept");
    expect_fetch(A1, 1'b0, "R7 A1 was evicted");
    expect_fetch(A0, 1'b1, "R7 A0 still kept");
  endtask

  task automatic t_lag();
    reg_write(6'h00);
    repeat (2) @(negedge clk);
    expect_fetch(A0, 1'b1, "R3 old settings within lag");
    reg_write(6'h01); settle();
    reg_write(6'h00);
    repeat (3) @(negedge clk);
    expect_fetch(A0, 1'b0, "R3 new settings after lag");
    reg_write(6'h01); settle();
    expect_fetch(A0, 1'b1, "R4 line survived disabled fetch");
  endtask

  task automatic t_global_lock();
    reg_write(6'h03);
    chk("R2 flush reads one", {24'd0, reg_rdata}, 32'h03);
    @(negedge clk);
    chk("R2 flush self clears", {24'd0, reg_rdata}, 32'h01);
    settle();
    expect_fetch(A0, 1'b0, "R12 flushed A0 misses");
    reg_write(6'h21); settle();
    expect_fetch(A1, 1'b0, "R8 miss fills invalid way");
    expect_fetch(A1, 1'b1, "R8 invalid way filled under lock");
    expect_fetch(A2, 1'b0, "R8 miss no eviction");
    chk("R6 penalty under global lock", last_req_n, 1);
    expect_fetch(A2, 1'b0, "R8 A2 not filled");
    expect_fetch(A0, 1'b1, "R8 A0 kept");
    expect_fetch(A1, 1'b1, "R8 A1 kept");
    reg_write(6'h01); settle();
  endtask

  task automatic t_auto_lock();
    logic h; logic [31:0] d;
    reg_write(6'h03); settle();
    reg_write(6'h09); settle();
    expect_fetch(A0, 1'b0, "R10 fill lock A0");
    expect_fetch(A1, 1'b0, "R10 fill lock A1");
    chk("R11 flag clear before conflict", {24'd0, reg_rdata}, 32'h09);
    expect_fetch(A2, 1'b0, "R11 conflicting miss");
    chk("R11 flag set", {24'd0, reg_rdata}, 32'h19);
    expect_fetch(A0, 1'b1, "R10 A0 locked kept");
    expect_fetch(A1, 1'b1, "R10 A1 locked kept");
    reg_write(6'h09);
    chk("R11 write zero clears", {24'd0, reg_rdata}, 32'h09);
    do_fetch(A2, 0, 1'b1, 6'h09, h, d);
    chk("R11 same-cycle miss data", d, mem_word(A2));
    chk("R11 set wins over clear", {24'd0, reg_rdata}, 32'h19);
    do_fetch(A1, 3, 1'b0, 6'd0, h, d);
    chk("R13 held hit", {31'd0, h}, 32'd1);
  endtask

  task automatic t_locked_invalid_unlock();
    reg_write(6'h03); settle();
    chk("R11 flag cleared by write", {24'd0, reg_rdata}, 32'h01);
    expect_fetch(A2, 1'b0, "R9 fill invalid locked way");
    expect_fetch(A2, 1'b1, "R9 invalid locked line filled");
    expect_fetch(A0, 1'b0, "R9 fill second locked way");
    expect_fetch(A0, 1'b1, "R9 second way filled");
    expect_fetch(A1, 1'b0, "R9 both locked miss");
    expect_fetch(A1, 1'b0, "R9 locked lines not replaced");
    reg_write(6'h05);
    chk("R2 unlock reads one", {24'd0, reg_rdata}, 32'h05);
    @(negedge clk);
    chk("R2 unlock self clears", {24'd0, reg_rdata}, 32'h01);
    settle();
    expect_fetch(A1, 1'b0, "R12 miss after unlock");
    expect_fetch(A1, 1'b1, "R12 replaced after unlock");
    expect_fetch(A0, 1'b1, "R7 mru kept after unlock");
    expect_fetch(A2, 1'b0, "R12 lru line evicted");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fill_lru();
    t_lag();
    t_global_lock();
    t_auto_lock();
    t_locked_invalid_unlock();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule